// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block counts down three independent 16-bit channels from one shared timebase. A byte-wide register bus configures and services it. Each channel has its own data address and its own output pin. One control address selects a channel and either programs that channel's counting mode and byte-access order or takes a snapshot of its running count.

The timebase is a clock enable. A parameterized divider derives it from the system clock so that it fires once per timer period of about 838 ns. Channel 0's output is meant to drive an interrupt request. Channel 2's output is also visible at bit 5 of a small speaker control register. That register holds four writable low bits.

Three counting modes are supported:
- an interrupt on terminal count;
- a rate generator that reloads itself;
- a square-wave generator that counts by two.

A control word that asks for anything else raises a one-cycle unsupported flag and is otherwise ignored. That covers BCD counting, the gate-driven modes (1, 4 and 5) and the multi-channel status command.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, all three channel outputs and the unsupported flag are low. The speaker nibble is zero. Every channel is idle, with low-then-high byte access and both byte pointers at the low byte.
- R2: The clock enable fires once every TICK_DIV system clocks. Its first pulse falls on the TICK_DIV-th rising edge after reset is released. Channel outputs change only on a clock-enable edge, a count load or a control word for that channel.
- R3: Address 3 accepts control writes with these fields:
  - bits 7:6 select the channel;
  - bits 5:4 set the access order (1 = low byte only, 2 = high byte only, 3 = low then high);
  - bits 3:1 set the mode (0, 2 or 3, with 6 and 7 acting as 2 and 3);
  - bit 0 must be 0.

  An accepted control word resets both byte pointers of the channel and stops its counting, so the count holds. It sets the output low for mode 0 and high for modes 2 and 3. Data writes must use the same access order that the control word set.
- R4: A control word is rejected if it has any of these:
  - bit 0 set;
  - mode 1, 4 or 5;
  - channel field 3;
  - bits 5:4 zero while bits 3:0 are nonzero.

  A rejected word changes no channel state. The unsupported flag is high in the cycle after the write.
- R5: Writes to a data address (0 to 2) change the reload value by access order:
  - low-only access gives {0x00, byte};
  - high-only access gives {byte, 0x00};
  - low-then-high access takes the low byte first and the high byte second.

  The count is loaded, and counting starts, only on the write that completes the value. In low-then-high access that is the high-byte write.
- R6: Reads of a data address return the live count: the low byte in low-only access and the high byte in high-only access. Low-then-high access alternates low and high.
- R7: A control word with bits 5:0 all zero latches the selected count. The next two reads of that channel return the latched low byte, then the latched high byte. After that, reads return to the live count.
- R8: In mode 0 the output goes low when the count is loaded. Each tick decrements the count. The output goes high on the tick that takes the count from 1 to 0, and it stays high until the next load or control word.
- R9: In mode 2 the output is high. A reload of 0 counts as 65536. On a tick at count 1 the channel reloads and drives the output low until the next tick.
- R10: In mode 3 the loaded value is rounded down to even, and a reload of 0 or 1 counts as 65536. Each tick subtracts 2. On a tick at count 2 the channel reloads and toggles its output, which is high at load.
- R11: Address 4 is the speaker register. A write stores bits 3:0. A read returns {2'b00, channel 2 output, 1'b0, stored nibble}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances read pointers) |
| bus_addr | input | 3 | 0..2 channel data, 3 control, 4 speaker |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| timer_irq | output | 1 | Channel 0 output, interrupt request |
| timer_out1 | output | 1 | Channel 1 output |
| speaker_tone | output | 1 | Channel 2 output |
| cfg_unsupported | output | 1 | One-cycle flag for a rejected control word |

## Verification
Read data is combinational. It is therefore sampled in the same cycle as the read strobe, and the pointer effect of that read appears one edge later. Control, latch and load effects are registered at the edge of the write, so outputs and the unsupported flag are checked at the following falling edge. Tick-driven results fall on a fixed grid of TICK_DIV edges after reset release. The bench counts edges from reset itself, aligns each timed sequence to just after a tick, and checks the output one edge before and exactly on the tick where it must change. Latched values are taken inside the tick-free window, so the expected count is exact.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NCH = 3;
  localparam logic [2:0] CTL_ADDR = 3'd3;
  localparam logic [2:0] SPK_ADDR = 3'd4;

  typedef enum logic [1:0] {ACC_LATCH = 2'd0, ACC_LO = 2'd1, ACC_HI = 2'd2, ACC_LOHI = 2'd3} acc_e;
  typedef enum logic [1:0] {CM_ONESHOT = 2'd0, CM_RATE = 2'd1, CM_SQUARE = 2'd2} cmode_e;

  // modes 0, 2, 3, 6, 7 are accepted
  function automatic logic mode_ok(input logic [2:0] m);
    return (m == 3'd0) || m[1];
  endfunction

  function automatic cmode_e decode_mode(input logic [2:0] m);
    if (m == 3'd0) return CM_ONESHOT;
    return m[0] ? CM_SQUARE : CM_RATE;
  endfunction

  // square wave: even count, 0 and 1 stand for 65536 (held as 0)
  function automatic logic [15:0] square_reload(input logic [15:0] r);
    return (r <= 16'd1) ? 16'd0 : {r[15:1], 1'b0};
  endfunction

  function automatic logic [15:0] stage_byte(input logic [15:0] r, input acc_e a,
                                             input logic hi, input logic [7:0] b);
    case (a)
      ACC_LO:  return {8'h00, b};
      ACC_HI:  return {b, 8'h00};
      default: return hi ? {b, r[7:0]} : {r[15:8], b};
    endcase
  endfunction

  function automatic logic [15:0] first_count(input cmode_e m, input logic [15:0] r);
    return (m == CM_SQUARE) ? square_reload(r) : r;
  endfunction

  function automatic logic [15:0] next_count(input cmode_e m, input logic [15:0] c,
                                             input logic [15:0] r);
    case (m)
      CM_RATE:   return (c == 16'd1) ? r : c - 16'd1;
      CM_SQUARE: return (c == 16'd2) ? square_reload(r) : c - 16'd2;
      default:   return c - 16'd1;
    endcase
  endfunction

  function automatic logic next_out(input cmode_e m, input logic [15:0] c, input logic o);
    case (m)
      CM_RATE:   return c != 16'd1;
      CM_SQUARE: return (c == 16'd2) ? ~o : o;
      default:   return (c == 16'd1) ? 1'b1 : o;
    endcase
  endfunction
endpackage

// File: rtl/pit_tick_gen.sv
module pit_tick_gen #(
  parameter int DIV = 42
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  logic [W-1:0] pre_q;

  assign tick = (pre_q == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_we,
  input  cmode_e     cfg_mode,
  input  acc_e       cfg_acc,
  input  logic       latch_we,
  input  logic       wr_we,
  input  logic       rd_re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       ch_out,
  output logic       load_evt
);
  cmode_e      mode_q;
  acc_e        acc_q;
  logic [15:0] count_q, reload_q, latch_q, reload_nx, src;
  logic        run_q, wr_hi_q, rd_hi_q, held_q;

  assign load_evt  = wr_we && (acc_q != ACC_LOHI || wr_hi_q);
  assign reload_nx = stage_byte(reload_q, acc_q, wr_hi_q, wdata);
  assign src       = held_q ? latch_q : count_q;
  assign rdata     = rd_hi_q ? src[15:8] : src[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= CM_ONESHOT;
      acc_q    <= ACC_LOHI;
      count_q  <= '0;
      reload_q <= '0;
      latch_q  <= '0;
      run_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      rd_hi_q  <= 1'b0;
      held_q   <= 1'b0;
      ch_out   <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= cfg_mode;
      acc_q   <= cfg_acc;
      run_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= (cfg_acc == ACC_HI);
      held_q  <= 1'b0;
      ch_out  <= (cfg_mode != CM_ONESHOT);
    end else begin
      if (latch_we) begin
        held_q  <= 1'b1;
        latch_q <= count_q;
        rd_hi_q <= 1'b0;
      end else if (rd_re) begin
        if (held_q) begin
          if (rd_hi_q) begin
            held_q  <= 1'b0;
            rd_hi_q <= (acc_q == ACC_HI);
          end else begin
            rd_hi_q <= 1'b1;
          end
        end else if (acc_q == ACC_LOHI) begin
          rd_hi_q <= ~rd_hi_q;
        end
      end
      if (wr_we) begin
        reload_q <= reload_nx;
        if (acc_q == ACC_LOHI) wr_hi_q <= ~wr_hi_q;
      end
      if (load_evt) begin
        count_q <= first_count(mode_q, reload_nx);
        run_q   <= 1'b1;
        ch_out  <= (mode_q != CM_ONESHOT);
      end else if (tick && run_q) begin
        count_q <= next_count(mode_q, count_q, reload_q);
        ch_out  <= next_out(mode_q, count_q, ch_out);
      end
    end
  end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import pit_pkg::*;
#(
  parameter int TICK_DIV = 42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       timer_irq,
  output logic       timer_out1,
  output logic       speaker_tone,
  output logic       cfg_unsupported
);
  logic           tick_w;
  logic [NCH-1:0] cfg_we, latch_we, load_evt, ch_out;
  logic [7:0]     ch_rdata [NCH];
  logic           ctl_wr, latch_cmd, cfg_ok;
  logic [1:0]     ctl_sel;
  logic [3:0]     spk_q;
  logic           unsup_q;

  pit_tick_gen #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick_w));

  assign ctl_wr    = bus_wr && (bus_addr == CTL_ADDR);
  assign ctl_sel   = bus_wdata[7:6];
  assign latch_cmd = ctl_wr && (ctl_sel != 2'd3) && (bus_wdata[5:0] == 6'd0);
  assign cfg_ok    = ctl_wr && (ctl_sel != 2'd3) && (bus_wdata[5:4] != 2'd0)
                     && !bus_wdata[0] && mode_ok(bus_wdata[3:1]);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign cfg_we[i]   = cfg_ok && (ctl_sel == 2'(i));
      assign latch_we[i] = latch_cmd && (ctl_sel == 2'(i));
      pit_channel u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .cfg_we   (cfg_we[i]),
        .cfg_mode (decode_mode(bus_wdata[3:1])),
        .cfg_acc  (acc_e'(bus_wdata[5:4])),
        .latch_we (latch_we[i]),
        .wr_we    (bus_wr && (bus_addr == 3'(i))),
        .rd_re    (bus_rd && (bus_addr == 3'(i))),
        .wdata    (bus_wdata),
        .rdata    (ch_rdata[i]),
        .ch_out   (ch_out[i]),
        .load_evt (load_evt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_q   <= '0;
      unsup_q <= 1'b0;
    end else begin
      unsup_q <= ctl_wr && !latch_cmd && !cfg_ok;
      if (bus_wr && bus_addr == SPK_ADDR) spk_q <= bus_wdata[3:0];
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0, 3'd1, 3'd2: bus_rdata = ch_rdata[bus_addr[1:0]];
      SPK_ADDR:         bus_rdata = {2'b00, ch_out[2], 1'b0, spk_q};
      default:          bus_rdata = 8'h00;
    endcase
  end

  assign timer_irq       = ch_out[0];
  assign timer_out1      = ch_out[1];
  assign speaker_tone    = ch_out[2];
  assign cfg_unsupported = unsup_q;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int DIV = 42
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [2:0] load_evt,
  input logic [2:0] cfg_evt,
  input logic [2:0] ch_out,
  input logic       unsup,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata
);
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= tick ? '0 : gap_q + 1;
  end

  // R2: clock enable spacing measured by an independent counter
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == 32'(DIV - 1));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  generate
    for (genvar i = 0; i < 3; i++) begin : g_q
      // R2: an output moves only on a tick, a load or a control word
      p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_evt[i] && !cfg_evt[i]) |=> $stable(ch_out[i]));
    end
  endgenerate

  // R4: the flag only follows a control-address write
  p_unsup_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> $past(bus_wr && bus_addr == 3'd3));

  // R11: speaker read layout
  p_spk_layout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4) |-> (bus_rdata[7:6] == 2'b00 && !bus_rdata[4]
                                      && bus_rdata[5] == ch_out[2]));
endmodule

bind tri_interval_timer pit_timer_chk #(.DIV(TICK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .load_evt  (load_evt),
  .cfg_evt   (cfg_we),
  .ch_out    (ch_out),
  .unsup     (cfg_unsupported),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic timer_irq, timer_out1, speaker_tone, cfg_unsupported;
  int n_run = 0, n_fail = 0;
  int bcyc = 0;
  bit done = 1'b0;

  tri_interval_timer #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq),
    .timer_out1(timer_out1), .speaker_tone(speaker_tone), .cfg_unsupported(cfg_unsupported));

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) bcyc <= rst_n ? bcyc + 1 : 0;

  // fields: ch[2] mode[3] acc[2] b0[8] b1[8] expected[16]
  localparam int NV = 7;
  localparam logic [38:0] TBL [NV] = '{
    {2'd0, 3'd0, 2'd3, 8'h34, 8'h12, 16'h1234},  // R5 low then high
    {2'd1, 3'd0, 2'd1, 8'h56, 8'h00, 16'h0056},  // R5 low only
    {2'd2, 3'd0, 2'd2, 8'h9A, 8'h00, 16'h9A00},  // R5 high only
    {2'd1, 3'd2, 2'd3, 8'h00, 8'h00, 16'h0000},  // R9 reload 0 loads as 0
    {2'd2, 3'd3, 2'd3, 8'h07, 8'h00, 16'h0006},  // R10 odd rounds down
    {2'd0, 3'd3, 2'd1, 8'h01, 8'h00, 16'h0000},  // R10 one becomes 65536
    {2'd1, 3'd6, 2'd3, 8'h20, 8'h03, 16'h0320}   // R3 mode 6 acts as 2
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi, lo};
  endtask

  // returns at a falling edge just after a tick (or at the phase start)
  task automatic sync(output int base);
    while (bcyc % DIV != 0) @(negedge clk);
    base = bcyc;
  endtask

  task automatic wait_to(input int n);
    while (bcyc < n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int b;
    logic [7:0] d;
    logic [15:0] v, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs", {13'd0, timer_irq, timer_out1, speaker_tone}, 16'd0);
    chk("R1 unsupported flag", {15'd0, cfg_unsupported}, 16'd0);
    rd(3'd4, d); chk("R1 speaker reg", {8'd0, d}, 16'h0000);
    // R11 speaker write keeps only low nibble
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R11 speaker nibble", {8'd0, d}, 16'h000F);

    // table: program, latch inside the tick-free window, read back
    for (int k = 0; k < NV; k++) begin
      logic [38:0] e;
      e = TBL[k];
      sync(b);
      wr(3'd3, {e[38:37], e[33:32], e[36:34], 1'b0});
      wr({1'b0, e[38:37]}, e[31:24]);
      if (e[33:32] == 2'd3) wr({1'b0, e[38:37]}, e[23:16]);
      wr(3'd3, {e[38:37], 6'd0});
      rd16({1'b0, e[38:37]}, v);
      chk($sformatf("R7 latched load row %0d", k), v, e[15:0]);
    end

    // R2 R8 mode 0 on channel 0, reload 3
    sync(b);
    wr(3'd3, 8'h10); wr(3'd0, 8'd3);
    chk("R8 low after load", {15'd0, timer_irq}, 16'd0);
    wait_to(b + 23); chk("R8 R2 low before third tick", {15'd0, timer_irq}, 16'd0);
    wait_to(b + 24); chk("R8 R2 high at terminal count", {15'd0, timer_irq}, 16'd1);
    wait_to(b + 48); chk("R8 stays high", {15'd0, timer_irq}, 16'd1);

    // R9 mode 2, reload 3
    sync(b);
    wr(3'd3, 8'h14); wr(3'd0, 8'd3);
    wait_to(b + 23); chk("R9 high before terminal", {15'd0, timer_irq}, 16'd1);
    wait_to(b + 24); chk("R9 pulse low", {15'd0, timer_irq}, 16'd0);
    wait_to(b + 31); chk("R9 low one tick", {15'd0, timer_irq}, 16'd0);
    wait_to(b + 32); chk("R9 back high", {15'd0, timer_irq}, 16'd1);

    // R9 reload 0 is maximum: one tick gives FFFF
    sync(b);
    wr(3'd3, 8'h54); wr(3'd1, 8'd0);
    wait_to(b + 9); wr(3'd3, 8'h40); rd16(3'd1, v);
    chk("R9 reload 0 as 65536", v, 16'hFFFF);

    // R10 mode 3 reload 4 on channel 1
    sync(b);
    wr(3'd3, 8'h56); wr(3'd1, 8'd4);
    wait_to(b + 15); chk("R10 high first half", {15'd0, timer_out1}, 16'd1);
    wait_to(b + 16); chk("R10 toggles low", {15'd0, timer_out1}, 16'd0);
    wait_to(b + 31); chk("R10 low second half", {15'd0, timer_out1}, 16'd0);
    wait_to(b + 32); chk("R10 toggles high", {15'd0, timer_out1}, 16'd1);

    // R10 reload 1 and decrement by two
    sync(b);
    wr(3'd3, 8'h96); wr(3'd2, 8'd1);
    wait_to(b + 9); wr(3'd3, 8'h80); rd16(3'd2, v);
    chk("R10 reload 1 then minus 2", v, 16'hFFFE);
    sync(b);
    wr(3'd3, 8'h96); wr(3'd2, 8'd8);
    wait_to(b + 17); wr(3'd3, 8'h80); rd16(3'd2, v);
    chk("R10 two ticks of 2", v, 16'h0004);

    // R3 control word resets read pointer and holds count
    sync(b);
    wr(3'd3, 8'h30); wr(3'd0, 8'h34); wr(3'd0, 8'h12);
    rd(3'd0, d); chk("R6 live low", {8'd0, d}, 16'h0034);
    wr(3'd3, 8'h30);
    rd(3'd0, d); chk("R3 read pointer reset", {8'd0, d}, 16'h0034);
    // R3 write pointer reset
    sync(b);
    wr(3'd3, 8'h30); wr(3'd0, 8'hAA); wr(3'd3, 8'h30);
    wr(3'd0, 8'h10); wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    rd16(3'd0, v); chk("R3 write pointer reset", v, 16'h0010);

    // R6 live alternation and high-only reads
    sync(b);
    wr(3'd3, 8'h30); wr(3'd0, 8'h78); wr(3'd0, 8'h56);
    rd(3'd0, d); chk("R6 alt low", {8'd0, d}, 16'h0078);
    rd(3'd0, d); chk("R6 alt high", {8'd0, d}, 16'h0056);
    rd(3'd0, d); chk("R6 alt low again", {8'd0, d}, 16'h0078);
    sync(b);
    wr(3'd3, 8'h20); wr(3'd0, 8'h44);
    rd(3'd0, d); chk("R6 high only", {8'd0, d}, 16'h0044);
    rd(3'd0, d); chk("R6 high only repeat", {8'd0, d}, 16'h0044);

    // R7 latch survives ticks then returns to live
    sync(b);
    wr(3'd3, 8'h30); wr(3'd0, 8'h00); wr(3'd0, 8'h01); wr(3'd3, 8'h00);
    wait_to(b + 9);
    rd16(3'd0, v); chk("R7 frozen snapshot", v, 16'h0100);
    rd(3'd0, d); chk("R7 back to live", {8'd0, d}, 16'h00FF);

    // R5 count waits for high byte; R3 channel held after control
    wr(3'd3, 8'h70);
    wr(3'd3, 8'h40); rd16(3'd1, v1);
    repeat (12) @(negedge clk);
    wr(3'd1, 8'h55);
    wr(3'd3, 8'h40); rd16(3'd1, v);
    chk("R5 R3 no load before high byte", v, v1);
    sync(b);
    wr(3'd1, 8'h02); wr(3'd3, 8'h40); rd16(3'd1, v);
    chk("R5 load on high byte", v, 16'h0255);

    // R4 rejected words leave channel 2 untouched; R11 reads its output
    wr(3'd3, 8'h94);
    rd(3'd4, d); chk("R11 speaker shows channel 2", {8'd0, d}, 16'h002F);
    wr(3'd3, 8'h91);
    chk("R4 flag after BCD", {15'd0, cfg_unsupported}, 16'd1);
    @(negedge clk); chk("R4 flag one cycle", {15'd0, cfg_unsupported}, 16'd0);
    chk("R4 BCD ignored", {15'd0, speaker_tone}, 16'd1);
    wr(3'd3, 8'h92); chk("R4 flag mode 1", {15'd0, cfg_unsupported}, 16'd1);
    wr(3'd3, 8'hD0); chk("R4 flag channel 3", {15'd0, cfg_unsupported}, 16'd1);
    wr(3'd3, 8'h80); chk("R4 latch not flagged", {15'd0, cfg_unsupported}, 16'd0);
    rd16(3'd2, v);
    rd(3'd4, d); chk("R4 channel 2 kept mode", {8'd0, d}, 16'h002F);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule